// File: doc/BRIEF.md
# Peripheral Register Bank with Byte-Lane Writes and Access Checks

This block is a subordinate on an APB4 peripheral bus. It holds a small bank of 32-bit registers. Each transfer takes a setup cycle and then one or more access cycles. The bank holds `ready_o` low for a configured number of access cycles before it completes the transfer, so it can stand in for a slow peripheral. On the completing cycle it either commits a write or returns read data. It raises `err_o` instead when the access is not allowed.

Writes carry a per-byte lane mask. Only the lanes whose mask bit is set change, so software can update one byte of a register without first reading the word. Reads ignore the mask and return the whole word.

Some accesses are refused: an address beyond the bank, and a write to the guarded register made without privilege. A refused access still completes, with the error flag raised. It changes nothing, and a refused read returns zero.

Back-pressure works as follows. The requester holds select, enable, address, direction, write data, mask and attributes steady for the whole access phase. It may consider the transfer finished only in the cycle where `ready_o` is high. The bank never raises `ready_o` outside an access phase.

Top module: `apb_regbank`

## Requirements
- R1: After reset every register reads as zero, and `ready_o`, `err_o` and `rdata_o` are all low.
- R2: In a transfer, `ready_o` stays low for exactly `WAIT_CYC` access cycles and goes high in access cycle `WAIT_CYC`+1. It goes high in the first access cycle when `WAIT_CYC` is 0, and it is never high while `sel_i` and `en_i` are not both high.
- R3: On a completing write, byte lane b (bits 8b+7..8b) of the addressed register takes `wdata_i` lane b only when `strb_i[b]` is 1. Every other lane keeps its value.
- R4: A read returns the full 32-bit register, whatever the value of `strb_i`.
- R5: `addr_i[3:2]` selects one of four registers. Any address of 0x10 or above is reserved: it completes with `err_o` high, a write to it changes no register, and a read of it returns zero.
- R6: Register 3 may be written only when `prot_i[0]` (the privileged attribute) is 1. An unprivileged write to it completes with `err_o` high and leaves it unchanged. Reads of register 3, and all accesses to other registers, ignore `prot_i`.
- R7: `err_o` is high only in a cycle where `sel_i`, `en_i` and `ready_o` are all high.
- R8: `rdata_o` is zero in every cycle other than the completing cycle of an accepted read.
- R9: A write takes effect at the clock edge that ends its completing cycle. The next transfer reads the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Subordinate selected |
| en_i | input | 1 | Access phase indicator |
| addr_i | input | ADDR_W | Byte address |
| wr_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 32 | Write data |
| strb_i | input | 4 | Write byte-lane mask |
| prot_i | input | 3 | Access attributes; bit 0 = privileged |
| ready_o | output | 1 | Transfer completes this cycle |
| rdata_o | output | 32 | Read data, valid when ready_o is high |
| err_o | output | 1 | Transfer refused, valid when ready_o is high |

## Verification
All three outputs are combinational from the wait counter and the stored words. `ready_o`, `err_o` and `rdata_o` are therefore due in the same cycle as the (`WAIT_CYC`+1)th access cycle, and a committed write is visible from the next transfer onward. The bench drives inputs on falling edges and samples 1 ns later. In each access cycle it counts wait cycles until `ready_o` rises, and it compares that count against `WAIT_CYC`. It reads data and error only in the completing cycle. It checks the idle value of all outputs during each setup cycle, and it proves a write took effect, or did not, by reading the register back in a later transfer.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int DATA_W    = 32;
  localparam int LANE_W    = 8;
  localparam int LANES     = DATA_W / LANE_W;
  localparam int PRIV_BIT  = 0;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_mask_t;

  // Merge new data into an old word under a lane mask.
  function automatic word_t lane_merge(word_t old_w, word_t new_w, lane_mask_t m);
    word_t r;
    for (int b = 0; b < LANES; b++)
      r[b*LANE_W +: LANE_W] = m[b] ? new_w[b*LANE_W +: LANE_W] : old_w[b*LANE_W +: LANE_W];
    return r;
  endfunction
endpackage

// File: rtl/regbank_decode.sv
module regbank_decode #(
  parameter int ADDR_W   = 8,
  parameter int NREG     = 4,
  parameter int PRIV_IDX = 3,
  localparam int IDX_W   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [2:0]        prot,
  output logic [IDX_W-1:0]  idx,
  output logic              bad
);
  import regbank_pkg::*;

  logic in_range;
  logic priv_viol;
  logic unused_bits;

  assign in_range    = addr[ADDR_W-1:2] < (ADDR_W-2)'(NREG);
  assign idx         = addr[IDX_W+1:2];
  assign priv_viol   = wr && (idx == IDX_W'(PRIV_IDX)) && !prot[PRIV_BIT];
  assign bad         = !in_range || priv_viol;
  assign unused_bits = ^{addr[1:0], prot[2:1]};
endmodule

// File: rtl/regbank_wait.sv
module regbank_wait #(
  parameter int WAIT_CYC = 2,
  localparam int CNT_W   = $clog2(WAIT_CYC + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic access,
  output logic ready
);
  logic [CNT_W-1:0] cnt_q;

  assign ready = access && (cnt_q == CNT_W'(WAIT_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (access && !ready) cnt_q <= cnt_q + 1'b1;
    else                       cnt_q <= '0;
  end
endmodule

// File: rtl/regbank_store.sv
module regbank_store #(
  parameter int NREG   = 4,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IDX_W-1:0]        idx,
  input  regbank_pkg::word_t      wdata,
  input  regbank_pkg::lane_mask_t strb,
  output regbank_pkg::word_t      rd_word
);
  import regbank_pkg::*;

  word_t words [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    word_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= '0;
      else if (we && idx == IDX_W'(r))     q <= lane_merge(q, wdata, strb);
    end
    assign words[r] = q;
  end

  assign rd_word = words[idx];
endmodule

// File: rtl/apb_regbank.sv
module apb_regbank #(
  parameter int ADDR_W   = 8,
  parameter int NREG     = 4,
  parameter int PRIV_IDX = 3,
  parameter int WAIT_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [31:0]       wdata_i,
  input  logic [3:0]        strb_i,
  input  logic [2:0]        prot_i,
  output logic              ready_o,
  output logic [31:0]       rdata_o,
  output logic              err_o
);
  import regbank_pkg::*;
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic             access;
  logic             done;
  logic             bad;
  logic [IDX_W-1:0] idx;
  word_t            rd_word;

  assign access = sel_i && en_i;
  assign done   = access && ready_o;

  regbank_decode #(.ADDR_W(ADDR_W), .NREG(NREG), .PRIV_IDX(PRIV_IDX)) u_dec (
    .addr(addr_i), .wr(wr_i), .prot(prot_i), .idx(idx), .bad(bad)
  );

  regbank_wait #(.WAIT_CYC(WAIT_CYC)) u_wait (
    .clk(clk), .rst_n(rst_n), .access(access), .ready(ready_o)
  );

  regbank_store #(.NREG(NREG)) u_store (
    .clk(clk), .rst_n(rst_n), .we(done && wr_i && !bad), .idx(idx),
    .wdata(wdata_i), .strb(strb_i), .rd_word(rd_word)
  );

  assign err_o   = done && bad;
  assign rdata_o = (done && !wr_i && !bad) ? rd_word : '0;
endmodule

// File: rtl/apb_regbank_checker.sv
module apb_regbank_checker #(
  parameter int ADDR_W   = 8,
  parameter int PRIV_IDX = 3,
  parameter int WAIT_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_i,
  input logic              en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic [2:0]        prot_i,
  input logic              ready_o,
  input logic [31:0]       rdata_o,
  input logic              err_o
);
  logic [31:0] acc_cnt;
  logic        acc;
  assign acc = sel_i && en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             acc_cnt <= '0;
    else if (acc && !ready_o) acc_cnt <= acc_cnt + 1;
    else                    acc_cnt <= '0;
  end

  a_r2_ready_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> acc);
  a_r2_ready_on_time: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> (ready_o == (acc_cnt == WAIT_CYC)));
  a_r7_err_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (acc && ready_o));
  a_r8_rdata_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && ready_o && !wr_i) |-> (rdata_o == 32'h0));
  a_r5_err_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !wr_i) |-> (rdata_o == 32'h0));
  a_r6_unpriv_write_err: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ready_o && wr_i && !prot_i[0] && addr_i[ADDR_W-1:2] == (ADDR_W-2)'(PRIV_IDX)) |-> err_o);
endmodule

bind apb_regbank apb_regbank_checker #(
  .ADDR_W(ADDR_W), .PRIV_IDX(PRIV_IDX), .WAIT_CYC(WAIT_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .en_i(en_i), .addr_i(addr_i),
  .wr_i(wr_i), .prot_i(prot_i), .ready_o(ready_o), .rdata_o(rdata_o), .err_o(err_o)
);

// File: tb/tb_apb_regbank.sv
`timescale 1ns/1ps
module tb_apb_regbank;
  localparam int WAIT = 2;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        sel = 0, en = 0, wr = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  strb = '0;
  logic [2:0]  prot = '0;
  logic        ready, err;
  logic [31:0] rdata;

  int nvec = 0, nfail = 0;
  logic [31:0] model [4];

  always #2 clk = ~clk;

  apb_regbank #(.ADDR_W(8), .NREG(4), .PRIV_IDX(3), .WAIT_CYC(WAIT)) dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .en_i(en), .addr_i(addr), .wr_i(wr),
    .wdata_i(wdata), .strb_i(strb), .prot_i(prot),
    .ready_o(ready), .rdata_o(rdata), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] a, input logic w, input logic [31:0] d,
                      input logic [3:0] s, input logic [2:0] p,
                      output logic [31:0] rd, output logic e);
    int waits = 0;
    @(negedge clk);
    sel = 1; en = 0; addr = a; wr = w; wdata = d; strb = s; prot = p;
    #1;
    chk(!ready && !err && rdata == 0, "R7/R8 setup idle", {ready, err, rdata[29:0]}, 0);
    @(negedge clk); en = 1; #1;
    while (!ready) begin
      waits++;
      @(negedge clk); #1;
    end
    rd = rdata; e = err;
    chk(waits == WAIT, "R2 wait count", waits, WAIT);
    @(negedge clk); sel = 0; en = 0;
  endtask

  task automatic wr_model(input int r, input logic [31:0] d, input logic [3:0] s);
    for (int b = 0; b < 4; b++) if (s[b]) model[r][b*8 +: 8] = d[b*8 +: 8];
  endtask

  initial begin
    logic [31:0] rd; logic e;
    for (int r = 0; r < 4; r++) model[r] = 0;
    repeat (2) @(negedge clk);
    #1;
    chk(!ready && !err && rdata == 0, "R1 reset outputs", {ready, err, rdata[29:0]}, 0);
    rst_n = 1;
    for (int r = 0; r < 4; r++) begin
      xfer(8'(r*4), 0, 0, 4'hF, 3'b001, rd, e);
      chk(rd == 0 && !e, "R1 reset contents", rd, 0);
    end

    // R3 / R4 / R9: every lane mask on every register, read back with an unrelated mask
    for (int r = 0; r < 4; r++)
      for (int s = 0; s < 16; s++) begin
        logic [31:0] d = 32'h1357_9BDF * (r*16 + s + 1);
        xfer(8'(r*4), 1, d, 4'(s), 3'b001, rd, e);
        chk(!e, "R3 write accepted", {31'b0, e}, 0);
        wr_model(r, d, 4'(s));
        xfer(8'(r*4), 0, 32'hDEAD_BEEF, ~4'(s), 3'b001, rd, e);
        chk(rd == model[r] && !e, "R3/R4/R9 readback", rd, model[r]);
      end

    // R5: reserved addresses refused, nothing changes
    for (int a = 16; a < 256; a += 4) begin
      xfer(8'(a), 1, 32'hFFFF_FFFF, 4'hF, 3'b001, rd, e);
      chk(e, "R5 reserved write err", {31'b0, e}, 1);
      xfer(8'(a), 0, 0, 4'hF, 3'b001, rd, e);
      chk(e && rd == 0, "R5 reserved read", rd, 0);
    end
    for (int r = 0; r < 4; r++) begin
      xfer(8'(r*4), 0, 0, 4'h0, 3'b000, rd, e);
      chk(rd == model[r] && !e, "R5 no change after reserved", rd, model[r]);
    end

    // R6: guarded register under every attribute value
    for (int p = 0; p < 8; p++) begin
      logic [31:0] d = 32'hA0B0_C0D0 + p;
      xfer(8'h0C, 1, d, 4'hF, 3'(p), rd, e);
      chk(e == !p[0], "R6 guarded write err", {31'b0, e}, {31'b0, !p[0]});
      if (p[0]) wr_model(3, d, 4'hF);
      xfer(8'h0C, 0, 0, 4'hF, 3'b000, rd, e);
      chk(rd == model[3] && !e, "R6 unprivileged read of reg3", rd, model[3]);
    end
    xfer(8'h00, 1, 32'h0BAD_F00D, 4'hF, 3'b000, rd, e);
    chk(!e, "R6 other reg ignores attributes", {31'b0, e}, 0);
    wr_model(0, 32'h0BAD_F00D, 4'hF);
    xfer(8'h00, 0, 0, 4'hF, 3'b110, rd, e);
    chk(rd == model[0] && !e, "R6 other reg readback", rd, model[0]);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule